// File: doc/BRIEF.md
# DMA Control, Status and Interrupt Register Block

This block is the software-facing register set of a descriptor-chained DMA engine. The host sees three 32-bit registers on a small byte-offset bus: a status word at 0x00, a control word at 0x10 and a next-descriptor pointer at 0x20. Writes take effect on the clock edge. Reads are combinational and have no side effects.

The chain walker sends the block one-cycle event pulses: transfer error, end of packet, one descriptor retired, and whole chain retired. It also drives a busy level. The block latches these events, counts retired descriptors and raises a level interrupt when an enabled cause is pending. Every cause passes through one global gate. In the other direction the block gives the walker a start pulse, a soft-reset pulse, the stop-on-error and ownership-clear flags, a polling enable with its interval, and the descriptor pointer.

Software acknowledges an interrupt by writing the control word with its top bit set. That write clears all latched events, the descriptor counter and the interrupt. In the same write it also stores the new control settings.

Top module: `dma_csr_irq`

## Requirements
- R1: After the asynchronous reset, all three registers read 0 (the status reads only the live busy bit) and `irq_o`, `start_o` and `soft_rst_o` are low.
- R2: The status word layout is: bit0 error, bit1 end of packet, bit2 descriptor done, bit3 chain done, bit4 busy. Bits 31:5 read 0. Bit4 follows `busy_i` in the same cycle.
- R3: An event pulse sets its status bit (0 to 3) at the next clock edge. The bit stays set until a clear or a soft reset.
- R4: Control bits 0 to 3 enable the cause for status bits 0 to 3 in the same order. An enabled latched cause drives `irq_o` high in the cycle after its event, provided the global enable is set.
- R5: Control bit4 is the global enable. While it is 0, `irq_o` stays low. Setting it while a cause is already latched raises `irq_o` after that write.
- R6: With control bit7 set and a nonzero threshold in control bits 15:8, the count cause latches when the number of descriptor-done pulses since the last clear reaches the threshold. A threshold of 0 never latches it. The counter saturates at 255.
- R7: A control write with bit31 set clears status bits 0 to 3, the counter, the count cause and hence `irq_o` at that edge, and stores the other bits. Bit31 reads back 0. An event arriving in the same cycle as the clear is kept.
- R8: A control write with bit5 set makes `start_o` high for exactly the next cycle. Bit5 reads back as written.
- R9: Control bit6 drives `stop_on_err_o`, bit17 `own_clr_o`, bit18 `poll_en_o` and bits 26:19 `poll_gap_o`. Bits 30:27 are not stored and read 0.
- R10: The pointer at 0x20 reads back the last value written and drives `next_desc_o`.
- R11: A control write with bit16 set zeroes control, pointer, status bits, counter and count cause at that edge, even if an event arrives in the same cycle. `soft_rst_o` is high for exactly the next cycle. Bit16 reads back 0.
- R12: Writes to 0x00 and to unmapped offsets change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ev_err_i | input | 1 | Transfer error pulse |
| ev_eop_i | input | 1 | End-of-packet pulse |
| ev_desc_i | input | 1 | Descriptor retired pulse |
| ev_chain_i | input | 1 | Chain retired pulse |
| busy_i | input | 1 | Walker busy level |
| irq_o | output | 1 | Level interrupt |
| start_o | output | 1 | One-cycle start request |
| soft_rst_o | output | 1 | One-cycle soft-reset request |
| stop_on_err_o | output | 1 | Halt walker on error |
| own_clr_o | output | 1 | Ownership-clear mode |
| poll_en_o | output | 1 | Descriptor polling enable |
| poll_gap_o | output | 8 | Polling interval in clocks |
| next_desc_o | output | 32 | Next descriptor pointer |

## Verification
The interrupt path is tested with single causes, with two causes stacked, and with the global gate first closed and then opened late. These cases show a per-cause enable apart from the global enable. The count cause is driven by runs of descriptor pulses that stop one short of the threshold and then reach it. It is also driven after a clear and with a threshold of zero. Together these runs show whether the counter compares, restarts on clear and stays disabled at zero. Clears and soft resets are issued in the same cycle as an event pulse, which shows which of the two takes priority.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned N_EV = 4;
  // status positions
  localparam int unsigned ST_BUSY = 4;
  // control positions
  localparam int unsigned C_GIE     = 4;
  localparam int unsigned C_START   = 5;
  localparam int unsigned C_STOP    = 6;
  localparam int unsigned C_IE_CNT  = 7;
  localparam int unsigned C_THR_LO  = 8;
  localparam int unsigned C_THR_HI  = 15;
  localparam int unsigned C_SRST    = 16;
  localparam int unsigned C_OWN     = 17;
  localparam int unsigned C_POLL    = 18;
  localparam int unsigned C_GAP_LO  = 19;
  localparam int unsigned C_GAP_HI  = 26;
  localparam int unsigned C_CLR     = 31;
  localparam int unsigned THR_W = C_THR_HI - C_THR_LO + 1;
  localparam int unsigned GAP_W = C_GAP_HI - C_GAP_LO + 1;
  // bits kept in the control register: 26:17 and 15:0
  localparam logic [DW-1:0] CTL_STORE_MASK = 32'h07FE_FFFF;
  typedef enum logic [1:0] {SEL_STAT, SEL_CTL, SEL_PTR, SEL_NONE} reg_sel_e;
endpackage

// File: rtl/dma_csr_ctl.sv
`timescale 1ns/1ps
module dma_csr_ctl
  import dma_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ptr_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] ptr_q,
  output logic          start_o,
  output logic          srst_o,
  output logic          clr_req,
  output logic          srst_req
);
  logic [DW-1:0] ctl_d, ptr_d;
  logic          start_d, srst_d, start_req, ctl_en, ptr_en;

  always_comb begin
    srst_req  = ctl_wr && wdata[C_SRST];
    clr_req   = ctl_wr && wdata[C_CLR] && !srst_req;
    start_req = ctl_wr && wdata[C_START] && !srst_req;
    ctl_en    = ctl_wr;
    ptr_en    = ptr_wr || srst_req;
    ctl_d     = srst_req ? '0 : (wdata & CTL_STORE_MASK);
    ptr_d     = srst_req ? '0 : wdata;
    start_d   = start_req;
    srst_d    = srst_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      srst_o  <= 1'b0;
    end else begin
      start_o <= start_d;
      srst_o  <= srst_d;
    end
  end

  assert_srst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (srst_o && ctl_q == '0 && ptr_q == '0));

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(ctl_wr && wdata[C_START]));

  assert_start_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && !$past(ctl_wr) |=> !start_o);
endmodule

// File: rtl/dma_csr_evt.sv
`timescale 1ns/1ps
module dma_csr_evt
  import dma_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  ev_i,
  input  logic             clr_i,
  input  logic             srst_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [N_EV-1:0]  sticky_q,
  output logic             hit_q
);
  localparam int unsigned DESC_IDX = 2;
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [N_EV-1:0]  sticky_d;
  logic [THR_W-1:0] cnt_q, cnt_d, cnt_base, cnt_inc;
  logic             hit_d, hit_new, upd_en, desc_ev;

  always_comb begin
    desc_ev  = ev_i[DESC_IDX];
    upd_en   = srst_i || clr_i || (|ev_i);
    cnt_base = clr_i ? '0 : cnt_q;
    cnt_inc  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + 1'b1;
    hit_new  = desc_ev && (thr_i != '0) && (cnt_inc >= thr_i);
    if (srst_i) begin
      sticky_d = '0;
      cnt_d    = '0;
      hit_d    = 1'b0;
    end else begin
      sticky_d = (clr_i ? '0 : sticky_q) | ev_i;
      cnt_d    = desc_ev ? cnt_inc : cnt_base;
      hit_d    = (clr_i ? 1'b0 : hit_q) | hit_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
    end else if (upd_en) begin
      sticky_q <= sticky_d;
      cnt_q    <= cnt_d;
      hit_q    <= hit_d;
    end
  end

  for (genvar g = 0; g < N_EV; g++) begin : g_chk
    assert_sticky_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[g] && !srst_i |=> sticky_q[g]);
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !(|ev_i) |=> (sticky_q == '0 && !hit_q));

  assert_thr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(thr_i) != '0);
endmodule

// File: rtl/dma_csr_gate.sv
`timescale 1ns/1ps
module dma_csr_gate
  import dma_csr_pkg::*;
(
  input  logic [N_EV-1:0] sticky_i,
  input  logic [N_EV-1:0] ev_en_i,
  input  logic            hit_i,
  input  logic            cnt_en_i,
  input  logic            gie_i,
  output logic            irq_o
);
  localparam int unsigned N_CAUSE = N_EV + 1;
  logic [N_CAUSE-1:0] cause;

  for (genvar g = 0; g < N_EV; g++) begin : g_cause
    assign cause[g] = sticky_i[g] & ev_en_i[g];
  end
  assign cause[N_EV] = hit_i & cnt_en_i;

  assign irq_o = gie_i & (|cause);
endmodule

// File: rtl/dma_csr_irq.sv
`timescale 1ns/1ps
module dma_csr_irq
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_OFS = 6'h00,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 6'h10,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ev_err_i,
  input  logic              ev_eop_i,
  input  logic              ev_desc_i,
  input  logic              ev_chain_i,
  input  logic              busy_i,
  output logic              irq_o,
  output logic              start_o,
  output logic              soft_rst_o,
  output logic              stop_on_err_o,
  output logic              own_clr_o,
  output logic              poll_en_o,
  output logic [GAP_W-1:0]  poll_gap_o,
  output logic [DW-1:0]     next_desc_o
);
  localparam int unsigned ST_PAD = DW - N_EV - 1;

  reg_sel_e        sel;
  logic [DW-1:0]   ctl_q, ptr_q;
  logic [N_EV-1:0] ev_vec, sticky;
  logic            hit, clr_req, srst_req;

  always_comb begin
    if (bus_addr == STAT_OFS)     sel = SEL_STAT;
    else if (bus_addr == CTL_OFS) sel = SEL_CTL;
    else if (bus_addr == PTR_OFS) sel = SEL_PTR;
    else                          sel = SEL_NONE;
  end

  assign ev_vec = {ev_chain_i, ev_desc_i, ev_eop_i, ev_err_i};

  dma_csr_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (bus_wr && sel == SEL_CTL),
    .ptr_wr   (bus_wr && sel == SEL_PTR),
    .wdata    (bus_wdata),
    .ctl_q    (ctl_q),
    .ptr_q    (ptr_q),
    .start_o  (start_o),
    .srst_o   (soft_rst_o),
    .clr_req  (clr_req),
    .srst_req (srst_req)
  );

  dma_csr_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev_vec),
    .clr_i    (clr_req),
    .srst_i   (srst_req),
    .thr_i    (ctl_q[C_THR_HI:C_THR_LO]),
    .sticky_q (sticky),
    .hit_q    (hit)
  );

  dma_csr_gate u_gate (
    .sticky_i (sticky),
    .ev_en_i  (ctl_q[N_EV-1:0]),
    .hit_i    (hit),
    .cnt_en_i (ctl_q[C_IE_CNT]),
    .gie_i    (ctl_q[C_GIE]),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: bus_rdata = {{ST_PAD{1'b0}}, busy_i, sticky};
      SEL_CTL:  bus_rdata = ctl_q;
      SEL_PTR:  bus_rdata = ptr_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign stop_on_err_o = ctl_q[C_STOP];
  assign own_clr_o     = ctl_q[C_OWN];
  assign poll_en_o     = ctl_q[C_POLL];
  assign poll_gap_o    = ctl_q[C_GAP_HI:C_GAP_LO];
  assign next_desc_o   = ptr_q;

  assert_gie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel == SEL_CTL && !bus_wdata[C_GIE] |=> !irq_o);

  assert_clr_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !(|ev_vec) |=> !irq_o);

  assert_stat_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_STAT |-> bus_rdata[DW-1:ST_BUSY+1] == '0);
endmodule

// File: tb/test_dma_csr_irq.sv
`timescale 1ns/1ps
module test_dma_csr_irq;
  localparam int NV = 50;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OE = 2'd2;
  localparam logic [5:0] AS = 6'h00, AC = 6'h10, AP = 6'h20;

  // {op, addr, data, expected, expected irq}
  localparam logic [72:0] VEC [NV] = '{
    {OR, AS, 32'h0, 32'h0, 1'b0},                 // 0  R1
    {OR, AC, 32'h0, 32'h0, 1'b0},                 // 1  R1
    {OW, AP, 32'hDEADBEE0, 32'h0, 1'b0},          // 2  R10
    {OR, AP, 32'h0, 32'hDEADBEE0, 1'b0},          // 3  R10
    {OW, AC, 32'h00000011, 32'h0, 1'b0},          // 4  R4
    {OE, AS, 32'h1, 32'h0, 1'b0},                 // 5
    {OR, AS, 32'h0, 32'h1, 1'b1},                 // 6  R3 R4
    {OE, AS, 32'h2, 32'h0, 1'b0},                 // 7
    {OR, AS, 32'h0, 32'h3, 1'b1},                 // 8  R3
    {OW, AC, 32'h80000011, 32'h0, 1'b0},          // 9  R7
    {OR, AS, 32'h0, 32'h0, 1'b0},                 // 10 R7
    {OR, AC, 32'h0, 32'h00000011, 1'b0},          // 11 R7
    {OW, AC, 32'h00000002, 32'h0, 1'b0},          // 12 R5
    {OE, AS, 32'h2, 32'h0, 1'b0},                 // 13
    {OR, AS, 32'h0, 32'h2, 1'b0},                 // 14 R5
    {OW, AC, 32'h00000012, 32'h0, 1'b0},          // 15
    {OR, AS, 32'h0, 32'h2, 1'b1},                 // 16 R5
    {OW, AC, 32'h80000012, 32'h0, 1'b0},          // 17
    {OR, AS, 32'h0, 32'h0, 1'b0},                 // 18 R7
    {OE, AS, 32'h10, 32'h0, 1'b0},                // 19 busy
    {OR, AS, 32'h0, 32'h10, 1'b0},                // 20 R2
    {OE, AS, 32'h0, 32'h0, 1'b0},                 // 21
    {OR, AS, 32'h0, 32'h0, 1'b0},                 // 22 R2
    {OW, AC, 32'h00000390, 32'h0, 1'b0},          // 23 R6 thr 3
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 24
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 25
    {OR, AS, 32'h0, 32'h4, 1'b0},                 // 26 R6
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 27
    {OR, AS, 32'h0, 32'h4, 1'b1},                 // 28 R6
    {OW, AC, 32'h80000390, 32'h0, 1'b0},          // 29
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 30
    {OR, AS, 32'h0, 32'h4, 1'b0},                 // 31 R6 counter restarted
    {OW, AC, 32'h80000090, 32'h0, 1'b0},          // 32 thr 0
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 33
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 34
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 35
    {OR, AS, 32'h0, 32'h4, 1'b0},                 // 36 R6 zero disables
    {OW, AC, 32'h80000014, 32'h0, 1'b0},          // 37
    {OR, AS, 32'h0, 32'h0, 1'b0},                 // 38 R7
    {OE, AS, 32'h4, 32'h0, 1'b0},                 // 39
    {OR, AS, 32'h0, 32'h4, 1'b1},                 // 40 R4 every desc
    {OW, AC, 32'h80000018, 32'h0, 1'b0},          // 41
    {OE, AS, 32'h8, 32'h0, 1'b0},                 // 42
    {OR, AS, 32'h0, 32'h8, 1'b1},                 // 43 R4 chain
    {OW, AC, 32'h80000000, 32'h0, 1'b0},          // 44
    {OW, AC, 32'h7D2E0060, 32'h0, 1'b0},          // 45 R9
    {OR, AC, 32'h0, 32'h052E0060, 1'b0},          // 46 R9
    {OR, 6'h30, 32'h0, 32'h0, 1'b0},              // 47 R12
    {OW, AS, 32'hFFFFFFFF, 32'h0, 1'b0},          // 48 R12
    {OR, AS, 32'h0, 32'h0, 1'b0}                  // 49 R12
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ev_err_i, ev_eop_i, ev_desc_i, ev_chain_i, busy_i;
  logic        irq_o, start_o, soft_rst_o, stop_on_err_o, own_clr_o, poll_en_o;
  logic [7:0]  poll_gap_o;
  logic [31:0] next_desc_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dma_csr_irq i_dma_csr_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_err_i(ev_err_i),
    .ev_eop_i(ev_eop_i), .ev_desc_i(ev_desc_i), .ev_chain_i(ev_chain_i),
    .busy_i(busy_i), .irq_o(irq_o), .start_o(start_o), .soft_rst_o(soft_rst_o),
    .stop_on_err_o(stop_on_err_o), .own_clr_o(own_clr_o), .poll_en_o(poll_en_o),
    .poll_gap_o(poll_gap_o), .next_desc_o(next_desc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string vreq(input int i);
    if (i < 2) return "R1";
    if (i < 4) return "R10";
    if (i < 9) return "R3/R4";
    if (i < 12) return "R7";
    if (i < 19) return "R5";
    if (i < 23) return "R2";
    if (i < 37) return "R6";
    if (i < 45) return "R4";
    if (i < 47) return "R9";
    return "R12";
  endfunction

  task automatic idle();
    bus_wr = 1'b0; bus_addr = AS; bus_wdata = '0;
    {ev_err_i, ev_eop_i, ev_desc_i, ev_chain_i} = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d;
    idle(); busy_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 start after reset", {31'b0, start_o}, 32'h0);
    chk("R1 soft_rst after reset", {31'b0, soft_rst_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      idle();
      bus_addr = v[70:65];
      case (v[72:71])
        OW: begin bus_wr = 1'b1; bus_wdata = v[64:33]; end
        OE: begin
          {busy_i, ev_chain_i, ev_desc_i, ev_eop_i, ev_err_i} = v[37:33];
        end
        default: begin
          #1;
          chk($sformatf("%s vec %0d rdata", vreq(i), i), bus_rdata, v[32:1]);
          chk($sformatf("%s vec %0d irq", vreq(i), i), {31'b0, irq_o}, {31'b0, v[0]});
        end
      endcase
      @(negedge clk);
    end
    idle();

    // R9: configuration outputs from vector 45
    chk("R9 stop_on_err", {31'b0, stop_on_err_o}, 32'h1);
    chk("R9 own_clr", {31'b0, own_clr_o}, 32'h1);
    chk("R9 poll_en", {31'b0, poll_en_o}, 32'h1);
    chk("R9 poll_gap", {24'b0, poll_gap_o}, 32'hA5);

    // R8: start pulse lasts one cycle
    bus_wr = 1'b1; bus_addr = AC; bus_wdata = 32'h0000_0020;
    @(negedge clk); idle();
    chk("R8 start high", {31'b0, start_o}, 32'h1);
    rd(AC, d); chk("R8 start bit readback", d, 32'h20);
    @(negedge clk);
    chk("R8 start low", {31'b0, start_o}, 32'h0);

    // R7: event in the same cycle as a clear is kept
    bus_wr = 1'b1; bus_addr = AC; bus_wdata = 32'h8000_0012; ev_eop_i = 1'b1;
    @(negedge clk); idle();
    rd(AS, d); chk("R7 event kept over clear", d, 32'h2);
    chk("R7 irq with kept event", {31'b0, irq_o}, 32'h1);
    @(negedge clk);

    // R10/R11: soft reset beats events and zeroes everything
    bus_wr = 1'b1; bus_addr = AP; bus_wdata = 32'h0000_1234;
    @(negedge clk);
    chk("R10 pointer out", next_desc_o, 32'h1234);
    bus_wr = 1'b1; bus_addr = AC; bus_wdata = 32'h0001_0011; ev_err_i = 1'b1;
    @(negedge clk); idle();
    chk("R11 soft_rst high", {31'b0, soft_rst_o}, 32'h1);
    rd(AC, d); chk("R11 control zero", d, 32'h0);
    rd(AP, d); chk("R11 pointer zero", d, 32'h0);
    rd(AS, d); chk("R11 status zero", d, 32'h0);
    chk("R11 irq low", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R11 soft_rst low", {31'b0, soft_rst_o}, 32'h0);

    // R12: unmapped write leaves pointer and control alone
    bus_wr = 1'b1; bus_addr = AP; bus_wdata = 32'h0000_00F0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h3C; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); idle();
    rd(AP, d); chk("R12 pointer untouched", d, 32'hF0);
    rd(AC, d); chk("R12 control untouched", d, 32'h0);

    // R1: asynchronous reset mid-run
    bus_wr = 1'b1; bus_addr = AC; bus_wdata = 32'h0000_0011; ev_err_i = 1'b1;
    @(negedge clk); idle();
    chk("R1 irq before reset", {31'b0, irq_o}, 32'h1);
    #1 rst_n = 1'b0; #1;
    chk("R1 irq cleared by reset", {31'b0, irq_o}, 32'h0);
    rd(AP, d); chk("R1 pointer cleared by reset", d, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule